// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Unit

This block is the synchronous front end of a pipelined burst SRAM. It holds a small memory of 36-bit words, each split into four 9-bit byte lanes. Every control input is sampled on the rising clock edge. There are two address strobes. The processor strobe is gated by the first chip enable and takes priority. The controller strobe acts whenever the processor strobe is not taken. Three chip enables decide, on load edges only, whether the device is selected or deselected. The low two address bits come from a 2-bit burst counter. A burst-advance input moves that counter on without a new address.

Writes use either a global write, which writes all lanes, or a byte-write enable combined with a per-lane select. A read takes the word at the address in force at one edge and shows it on the data output after the next edge. The data-output enable is combinational from an active-low output-enable input. It is held off for the first read after a deselected period. A sleep input freezes the device: nothing is loaded, advanced, read or written. The bidirectional data bus is split into a write-data input, a read-data output and a read-data-enable output.

Top module: `psram_ctl`

## Requirements
- R1: While reset is low and after it is released, `rdata` is all zeros, `rdata_en` is 0 and the device is deselected.
- R2: A strobe that is acted on loads `addr` only if `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A strobe acted on with any enable inactive deselects the device. While deselected, no read or write takes place and `rdata_en` stays 0.
- R3: When `cpu_strobe_n` and `ctl_strobe_n` are both 0 and `en_a_n`=0, only the processor strobe is acted on. The edge of a processor-strobe load ignores the write controls, so that access is a read.
- R4: `cpu_strobe_n`=0 has no effect while `en_a_n`=1. `ctl_strobe_n`=0 is still acted on in that case.
- R5: On edges where no strobe is acted on, the chip enables do not change the selected or deselected state.
- R6: A load copies `addr[1:0]` into the burst counter. Each later edge with `burst_n`=0, while selected, first adds 1 modulo 4 to the counter and then accesses the new address. The bits above bit 1 stay fixed.
- R7: Each edge that accesses the memory while selected uses the current address. With `wr_all_n`=0 it writes all four lanes from `wdata`.
- R8: With `wr_all_n`=1 and `wr_lane_n`=0, lane i (`wdata[9i+8:9i]`) is written only if `lane_n[i]`=0. An access with both write controls high is a read.
- R9: The word read at an access edge appears on `rdata` after the following edge. `rdata` holds between reads. `rdata_en` is 1 only for a valid read result, with `out_en_n`=0 and `sleep`=0.
- R10: The first read after a deselected period gives `rdata_en`=0 while its data is on `rdata`, even when `out_en_n`=0.
- R11: While `sleep`=1, no strobe, advance, read or write has effect, the stored words are kept and `rdata_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| en_a_n | input | 1 | Chip enable, active low, also gates the processor strobe |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| burst_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_lane_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | LANES*LW | Write data |
| rdata | output | LANES*LW | Registered read data |
| rdata_en | output | 1 | Read data drive enable |

## Verification
The hardest situation to reach is a read that follows a deselected period while output enable is already low. Reaching it needs a load that deselects, then a valid load that reselects, and then a read with no write in between. The bench builds this on purpose: it deselects through the controller strobe with the first enable high and with the third enable inactive, then reselects at a fresh address. Random stimulus also keeps reaching it, because the enables are often inactive on strobe edges. A cycle-level reference model judges every cycle.

// File: rtl/psram_ctl.sv
module psram_ctl #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                cpu_strobe_n,
  input  logic                ctl_strobe_n,
  input  logic                en_a_n,
  input  logic                en_b,
  input  logic                en_c_n,
  input  logic                burst_n,
  input  logic                wr_all_n,
  input  logic                wr_lane_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic                out_en_n,
  input  logic                sleep,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_en
);
  localparam int DEPTH = 1 << AW;

  logic          sel_q, dsl_q, pr_q, pm_q, vld_q, msk_q;
  logic [AW-1:0] ar_q, a_d;
  logic          sel_d;

  wire en_ok = !en_a_n && en_b && !en_c_n;
  wire p_hit = !sleep && !cpu_strobe_n && !en_a_n;
  wire c_hit = !sleep && !ctl_strobe_n && !p_hit;
  wire load  = p_hit || c_hit;

  always_comb begin
    sel_d = sel_q;
    a_d   = ar_q;
    if (load) begin
      sel_d = en_ok;
      if (en_ok) a_d = addr;
    end else if (!sleep && sel_q && !burst_n) begin
      a_d = {ar_q[AW-1:2], 2'(ar_q[1:0] + 2'd1)};
    end
  end

  wire access = !sleep && sel_d;
  wire wcyc   = !p_hit && (!wr_all_n || !wr_lane_n);
  wire rd     = access && !wcyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      dsl_q <= 1'b1;
      ar_q  <= '0;
      pr_q  <= 1'b0;
      pm_q  <= 1'b0;
      vld_q <= 1'b0;
      msk_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ar_q  <= a_d;
      pr_q  <= rd;
      pm_q  <= rd && dsl_q;
      vld_q <= pr_q;
      msk_q <= pm_q;
      if (!sel_d)  dsl_q <= 1'b1;
      else if (rd) dsl_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    logic [LW-1:0] q;
    wire we = access && !p_hit && (!wr_all_n || (!wr_lane_n && !lane_n[i]));

    always_ff @(posedge clk) begin
      if (we) bank[a_d] <= wdata[i*LW +: LW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (pr_q) q <= bank[ar_q];
    end

    assign rdata[i*LW +: LW] = q;
  end

  assign rdata_en = vld_q && !msk_q && !out_en_n && !sleep;
endmodule

// File: rtl/psram_ctl_chk.sv
module psram_ctl_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_strobe_n,
  input logic          ctl_strobe_n,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic          burst_n,
  input logic          wr_all_n,
  input logic          wr_lane_n,
  input logic          sleep,
  input logic          sel_q,
  input logic [AW-1:0] ar_q,
  input logic          vld_q,
  input logic [DW-1:0] rdata,
  input logic          rdata_en
);
  logic p, ld, ok;
  assign p  = !sleep && !cpu_strobe_n && !en_a_n;
  assign ld = p || (!sleep && !ctl_strobe_n);
  assign ok = !en_a_n && en_b && !en_c_n;

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ok) |-> ##2 !rdata_en);

  p_strobe_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p && !ctl_strobe_n && ok) |-> ##2 vld_q);

  p_cpu_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && en_a_n && !cpu_strobe_n && ctl_strobe_n) |=> (sel_q == $past(sel_q)));

  p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (sel_q == $past(sel_q)));

  p_burst_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !ld && !sleep && !burst_n) |=>
      (ar_q[1:0] == 2'($past(ar_q[1:0]) + 2'd1)) && (ar_q[AW-1:2] == $past(ar_q[AW-1:2])));

  p_read_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!p && ld && ok && wr_all_n && wr_lane_n) |-> ##2 vld_q);

  p_first_read_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && ld && ok) |-> ##2 !rdata_en);

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ##2 $stable(rdata));
endmodule

bind psram_ctl psram_ctl_chk #(.AW(AW), .DW(LANES*LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
  .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .burst_n(burst_n),
  .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .sleep(sleep), .sel_q(sel_q),
  .ar_q(ar_q), .vld_q(vld_q), .rdata(rdata), .rdata_en(rdata_en)
);

// File: tb/psram_ctl_tb_top.sv
module psram_ctl_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic cpu_strobe_n, ctl_strobe_n, en_a_n, en_b, en_c_n, burst_n;
  logic wr_all_n, wr_lane_n, out_en_n, sleep;
  logic [LANES-1:0] lane_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_en;

  int total = 0, bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  psram_ctl #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .burst_n(burst_n), .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_n(lane_n),
    .out_en_n(out_en_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  // reference model, advanced at every rising edge from the inputs the bench drives
  logic [DW-1:0] m_mem [1<<AW];
  logic [DW-1:0] m_dout;
  logic [AW-1:0] m_ar;
  bit m_sel, m_dsl, m_pr, m_pm, m_vld, m_msk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = '0; m_ar = '0; m_sel = 0; m_dsl = 1; m_pr = 0; m_pm = 0; m_vld = 0; m_msk = 0;
    end else begin
      bit ok, p, ld, nsel, acc, wc, rdop;
      logic [AW-1:0] na;
      if (m_pr) m_dout = m_mem[m_ar];
      m_vld = m_pr;
      m_msk = m_pm;
      ok = !en_a_n && en_b && !en_c_n;
      p  = !sleep && !cpu_strobe_n && !en_a_n;
      ld = p || (!sleep && !ctl_strobe_n);
      nsel = m_sel; na = m_ar;
      if (ld) begin
        nsel = ok;
        if (ok) na = addr;
      end else if (!sleep && m_sel && !burst_n) begin
        na[1:0] = m_ar[1:0] + 2'd1;
      end
      acc = !sleep && nsel;
      wc  = !p && (!wr_all_n || !wr_lane_n);
      if (acc && wc)
        for (int i = 0; i < LANES; i++)
          if (!wr_all_n || !lane_n[i]) m_mem[na][i*LW +: LW] = wdata[i*LW +: LW];
      rdop = acc && !wc;
      m_pm = rdop && m_dsl;
      if (!nsel) m_dsl = 1;
      else if (rdop) m_dsl = 0;
      m_pr = rdop;
      m_sel = nsel;
      m_ar = na;
    end
  end

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom, $urandom};
    return r[DW-1:0];
  endfunction

  task automatic idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; en_a_n = 0; en_b = 1; en_c_n = 0;
    burst_n = 1; wr_all_n = 1; wr_lane_n = 1; lane_n = '1; out_en_n = 0; sleep = 0;
    wdata = rnd_word();
  endtask

  task automatic step();
    bit exp_en;
    @(negedge clk);
    exp_en = m_vld && !m_msk && !out_en_n && !sleep;
    total++;
    if (rdata !== m_dout) begin
      bad++;
      $display("FAIL %s rdata act=%h exp=%h t=%0t", tag, rdata, m_dout, $time);
    end
    total++;
    if (rdata_en !== exp_en) begin
      bad++;
      $display("FAIL %s rdata_en act=%b exp=%b t=%0t", tag, rdata_en, exp_en, $time);
    end
  endtask

  task automatic load_ctl(input logic [AW-1:0] a);
    idle(); ctl_strobe_n = 0; addr = a;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); addr = '0;
    // R1: reset state
    tag = "R1";
    repeat (3) step();
    rst_n = 1;
    repeat (2) step();

    // R7: fill every word with global-write bursts
    tag = "R7";
    for (int b = 0; b < (1 << AW) / 4; b++) begin
      load_ctl(AW'(b * 4)); wr_all_n = 0; step();
      for (int j = 1; j < 4; j++) begin idle(); burst_n = 0; wr_all_n = 0; step(); end
    end

    // R6: wrapping burst read from an unaligned start
    tag = "R6";
    load_ctl(AW'(22)); step();
    repeat (4) begin idle(); burst_n = 0; step(); end
    idle(); step(); step();

    // R8: byte-lane write, then read back; select with enable high writes nothing
    tag = "R8";
    load_ctl(AW'(9)); wr_lane_n = 0; lane_n = 4'b1010; step();
    load_ctl(AW'(10)); lane_n = 4'b0000; step();
    load_ctl(AW'(9)); step();
    idle(); step(); step();

    // R3: strobe collision; processor strobe wins and ignores the write
    tag = "R3";
    idle(); cpu_strobe_n = 0; ctl_strobe_n = 0; addr = AW'(13); wr_all_n = 0; step();
    idle(); step(); step();
    idle(); cpu_strobe_n = 0; addr = AW'(14); step();
    idle(); wr_all_n = 0; step();
    idle(); step(); step();

    // R4: processor strobe gated by the first enable; controller strobe not gated
    tag = "R4";
    idle(); en_a_n = 1; cpu_strobe_n = 0; addr = AW'(40); step(); step();
    idle(); en_a_n = 1; ctl_strobe_n = 0; addr = AW'(41); step();
    idle(); step(); step(); step();

    // R10: reselect after deselect, first read masked
    tag = "R10";
    load_ctl(AW'(30)); step();
    idle(); step(); step(); step();

    // R5: enables ignored on non-load edges
    tag = "R5";
    idle(); en_b = 0; step(); step();
    idle(); en_c_n = 1; en_a_n = 1; step(); step();

    // R2: loads with an inactive enable deselect; then a valid load
    tag = "R2";
    load_ctl(AW'(5)); en_c_n = 1; step();
    idle(); wr_all_n = 0; step(); step();
    load_ctl(AW'(5)); en_b = 0; step();
    load_ctl(AW'(5)); step();
    idle(); step(); step();

    // R11: sleep blocks everything and keeps contents
    tag = "R11";
    load_ctl(AW'(7)); wr_all_n = 0; sleep = 1; step();
    idle(); sleep = 1; burst_n = 0; wr_all_n = 0; step();
    idle(); sleep = 1; cpu_strobe_n = 0; addr = AW'(8); step(); step();
    idle(); step();
    load_ctl(AW'(7)); step();
    idle(); step(); step();

    // R9: random traffic against the model
    tag = "R9";
    for (int n = 0; n < 4000; n++) begin
      cpu_strobe_n = !($urandom % 6 == 0);
      ctl_strobe_n = !($urandom % 6 == 0);
      en_a_n = ($urandom % 8 == 0);
      en_b   = !($urandom % 8 == 0);
      en_c_n = ($urandom % 8 == 0);
      burst_n = $urandom % 2 == 0;
      wr_all_n = !($urandom % 8 == 0);
      wr_lane_n = !($urandom % 6 == 0);
      lane_n = 4'($urandom);
      out_en_n = ($urandom % 8 == 0);
      sleep = ($urandom % 32 == 0);
      addr = AW'($urandom);
      wdata = rnd_word();
      step();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule